// File: doc/BRIEF.md
# Strip-Mined Vector Length Sequencer

This block takes one job of `n` elements and divides it into chunks that a vector unit with a fixed maximum vector length can handle. A single-cycle start pulse carries the total count. The block then offers chunks one at a time over a valid/ready handshake. Each chunk carries the index of its first element and the number of elements it covers. The block computes no addresses and does no arithmetic on element data.

The short, odd-sized part of the job is issued first. Every later chunk has the full maximum length, so only the opening chunk needs a length other than the maximum. A one-cycle done pulse follows acceptance of the last chunk. An empty job (`n == 0`) produces only the done pulse.

Top module: `vl_strip_seq`

## Requirements
- R1: After reset, `chunk_valid`, `busy` and `done` are all 0.
- R2: A start pulse seen while idle with `total_len` nonzero raises `chunk_valid` on the next cycle. The first chunk has `chunk_base` 0 and `chunk_len` equal to `total_len` modulo `MAXVL`.
- R3: When `total_len` is a nonzero multiple of `MAXVL`, no zero-length chunk is offered. The first chunk is then `MAXVL` long. Every offered `chunk_len` lies between 1 and `MAXVL`.
- R4: Every chunk after the first has `chunk_len` equal to `MAXVL`. Its `chunk_base` equals the previous chunk's base plus the previous chunk's length.
- R5: A job of `n` elements produces exactly ceil(n/MAXVL) chunks, and their lengths sum to `n`.
- R6: While `chunk_valid` is 1 and `chunk_ready` is 0, `chunk_valid`, `chunk_base` and `chunk_len` stay unchanged on the next cycle.
- R7: `done` is 1 for exactly one cycle, in the cycle after the final chunk is accepted. `chunk_valid` is 0 in that cycle.
- R8: A start with `total_len` of 0 offers no chunk and raises `done` for one cycle, in the cycle after the start.
- R9: `busy` follows `chunk_valid`. A start pulse while `busy` is 1 is ignored, and the chunk sequence of the running job is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse, taken only while idle |
| total_len | input | LEN_W | Total element count of the job, sampled with `start` |
| busy | output | 1 | A job is in progress |
| chunk_valid | output | 1 | A chunk is offered |
| chunk_ready | input | 1 | The consumer takes the offered chunk |
| chunk_base | output | LEN_W | Index of the first element of the chunk |
| chunk_len | output | clog2(MAXVL+1) | Element count of the chunk |
| done | output | 1 | One-cycle pulse when the job has ended |

## Verification
The bound checker checks these rules on every cycle:
- chunks are held stable under backpressure;
- chunk lengths stay in range;
- each chunk's base and length follow from the chunk before it;
- done lasts one cycle and never overlaps a valid chunk;
- the reaction to a start while idle, for both empty and nonempty jobs.

Some properties concern a whole job and are shown only by the bench scenarios. These are the exact number of chunks, the sum of their lengths, and the remainder value of the first chunk for chosen sizes (1, MAXVL-1, MAXVL, MAXVL+1, multiples, the largest count). The same holds for a start pulse sent in the middle of a job being ignored.

// File: rtl/vl_strip_seq.sv
module vl_strip_seq #(
  parameter int MAXVL = 64,
  parameter int LEN_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [LEN_W-1:0]             total_len,
  output logic                         busy,
  output logic                         chunk_valid,
  input  logic                         chunk_ready,
  output logic [LEN_W-1:0]             chunk_base,
  output logic [$clog2(MAXVL+1)-1:0]   chunk_len,
  output logic                         done
);
  localparam int VL_W = $clog2(MAXVL+1);

  logic             vld_q, done_q;
  logic [LEN_W-1:0] base_q, left_q;
  logic [VL_W-1:0]  len_q;
  logic [LEN_W-1:0] rem;
  logic [VL_W-1:0]  first_len;
  logic [LEN_W-1:0] len_ext;

  assign rem       = total_len % LEN_W'(MAXVL);
  assign first_len = (rem == '0) ? VL_W'(MAXVL) : rem[VL_W-1:0];
  assign len_ext   = LEN_W'(len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      left_q <= '0;
      len_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!vld_q) begin
        if (start) begin
          if (total_len == '0) begin
            done_q <= 1'b1;
          end else begin
            vld_q  <= 1'b1;
            base_q <= '0;
            len_q  <= first_len;
            left_q <= total_len;
          end
        end
      end else if (chunk_ready) begin
        if (left_q == len_ext) begin
          vld_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          base_q <= base_q + len_ext;
          left_q <= left_q - len_ext;
          len_q  <= VL_W'(MAXVL);
        end
      end
    end
  end

  assign busy        = vld_q;
  assign chunk_valid = vld_q;
  assign chunk_base  = base_q;
  assign chunk_len   = len_q;
  assign done        = done_q;
endmodule

// File: rtl/vl_strip_seq_chk.sv
module vl_strip_seq_chk #(
  parameter int MAXVL = 64,
  parameter int LEN_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic [LEN_W-1:0]           total_len,
  input logic                       busy,
  input logic                       chunk_valid,
  input logic                       chunk_ready,
  input logic [LEN_W-1:0]           chunk_base,
  input logic [$clog2(MAXVL+1)-1:0] chunk_len,
  input logic                       done
);
  localparam int VL_W = $clog2(MAXVL+1);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=> (chunk_valid && $stable(chunk_base) && $stable(chunk_len))); // R6

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_len != '0 && chunk_len <= VL_W'(MAXVL))); // R3

  AST_NEXT_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_ready) |=>
      (!chunk_valid || (chunk_len == VL_W'(MAXVL) &&
                        chunk_base == $past(chunk_base) + LEN_W'($past(chunk_len))))); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chunk_valid); // R7

  AST_EMPTY_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && total_len == '0) |=> (done && !chunk_valid)); // R8

  AST_FIRST_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && total_len != '0) |=> (chunk_valid && chunk_base == '0)); // R2

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy == chunk_valid); // R9
endmodule

bind vl_strip_seq vl_strip_seq_chk #(.MAXVL(MAXVL), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
  .busy(busy), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
  .chunk_base(chunk_base), .chunk_len(chunk_len), .done(done)
);

// File: tb/sim_vl_strip_seq.sv
`timescale 1ns/1ps
module sim_vl_strip_seq;
  localparam int MAXVL = 64;
  localparam int LEN_W = 16;
  localparam int VL_W  = $clog2(MAXVL+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic chunk_ready = 1'b0;
  logic busy, chunk_valid, done;
  logic [LEN_W-1:0] chunk_base;
  logic [VL_W-1:0] chunk_len;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  vl_strip_seq #(.MAXVL(MAXVL), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .busy(busy), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_base(chunk_base), .chunk_len(chunk_len), .done(done)
  );

  function automatic int exp_first(input int n);
    return (n % MAXVL == 0) ? MAXVL : n % MAXVL;
  endfunction

  function automatic int exp_count(input int n);
    return (n + MAXVL - 1) / MAXVL;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_job(input int n, input int ready_pct, input bit poke);
    int eb, el, left, cnt, sum;
    bit fin, first, held, rdy;
    @(negedge clk);
    start = 1'b1;
    total_len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
    total_len = LEN_W'(n + 5);
    if (n == 0) begin
      check("R8 done after empty start", int'(done), 1);
      check("R8 no chunk", int'(chunk_valid), 0);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
      check("R8 still no chunk", int'(chunk_valid), 0);
      return;
    end
    eb = 0; el = exp_first(n); left = n; cnt = 0; sum = 0;
    fin = 0; first = 1; held = 0;
    while (!fin) begin
      if (first) begin
        check("R2 valid after start", int'(chunk_valid), 1);
        check("R9 busy", int'(busy), 1);
        check("R2 first base", int'(chunk_base), 0);
        check((n % MAXVL == 0) ? "R3 full first len" : "R2 remainder len", int'(chunk_len), el);
      end else if (held) begin
        check("R6 valid held", int'(chunk_valid), 1);
        check("R6 base held", int'(chunk_base), eb);
        check("R6 len held", int'(chunk_len), el);
      end else begin
        check("R4 valid", int'(chunk_valid), 1);
        check("R4 base advance", int'(chunk_base), eb);
        check("R4 full len", int'(chunk_len), el);
      end
      check("R7 no done mid job", int'(done), 0);
      if (poke && first) begin
        start = 1'b1;
        total_len = LEN_W'(n + 7);
      end
      rdy = (($urandom % 100) < ready_pct);
      chunk_ready = rdy;
      first = 0;
      @(negedge clk);
      start = 1'b0;
      chunk_ready = 1'b0;
      if (rdy) begin
        cnt++; sum += el; left -= el; eb += el; el = MAXVL; held = 0;
        if (left == 0) begin
          check("R7 done after last", int'(done), 1);
          check("R7 valid low at done", int'(chunk_valid), 0);
          check("R9 busy low", int'(busy), 0);
          check("R5 chunk count", cnt, exp_count(n));
          check("R5 length sum", sum, n);
          @(negedge clk);
          check("R7 done one cycle", int'(done), 0);
          fin = 1;
        end
      end else begin
        held = 1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    check("R1 valid reset", int'(chunk_valid), 0);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(chunk_valid), 0);
    run_job(0, 100, 0);
    run_job(1, 100, 0);
    run_job(MAXVL - 1, 50, 0);
    run_job(MAXVL, 100, 0);
    run_job(MAXVL + 1, 30, 0);
    run_job(3 * MAXVL, 60, 0);
    run_job(5 * MAXVL + 17, 40, 1);
    run_job(2 * MAXVL, 70, 1);
    run_job(0, 100, 0);
    run_job((1 << LEN_W) - 1, 100, 0);
    for (int i = 0; i < 40; i++) begin
      run_job(int'($urandom % 1200), 20 + int'($urandom % 81), bit'($urandom % 2));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule